// File: doc/BRIEF.md
# Stream-Filtered Event Selector

This block sits in front of a bank of event counters and decides, on every clock, which of them should advance. Each counter is configured by two 32-bit words held outside the block: an event-type word that picks one pulse out of the event vector and holds a span bit, and a stream-match word that qualifies which transaction stream identifiers are counted. The block compares the stream identifier of the current transaction against the match word and gates the chosen event pulse with the result. It then registers the outcome into one increment strobe per counter.

Matching is either exact or by pattern. In pattern mode the bits to ignore are not held in a separate mask register. They are written into the match word itself as a run of trailing ones closed by a single zero, and every bit at or below that zero is a don't-care. An all-ones match word in pattern mode therefore accepts every stream. A mode input makes all counters share the span and match value of counter 0, while each counter keeps its own event number. Event 0 is the cycle event, which ignores the filter. Event numbers beyond the implemented range, and events marked unsupported by a parameter, never produce an increment.

Top module: `stream_event_filter`

## Requirements
- R1: In the event-type word, bits 15:0 hold the event number and bit 29 is the span bit (0 exact, 1 pattern). All other bits of that word have no effect.
- R2: With span 0, a counter increments only when the stream identifier equals the 32-bit match word.
- R3: With span 1, the lowest zero bit of the match word and every bit below it are ignored, and all higher bits must equal the stream identifier. For example, match 0x42 accepts 0x42 and 0x43 but rejects 0x40 and 0x44, and match 0x47 accepts 0x40 through 0x4F.
- R4: With span 1 and an all-ones match word, every stream identifier is accepted.
- R5: Event number 0 (cycles) ignores span and match, and increments whenever event pulse 0 is high.
- R6: An event number at or above NUM_EVT, or at or above 128, never produces an increment.
- R7: An event number whose bit in the EVT_SUP parameter is 0 never produces an increment.
- R8: With global_mode_i high, every counter uses the span bit and match word of counter 0 and its own event number.
- R9: With global_mode_i low, each counter uses its own span bit and match word.
- R10: inc_o[c] is registered. It reflects the inputs present at the previous rising clock edge, and it is 0 during and right after reset.
- R11: A counter never increments unless the event pulse its event number selects was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| global_mode_i | input | 1 | 1: all counters share the filter of counter 0 |
| evt_pulse_i | input | NUM_EVT | Event pulses, indexed by event number |
| sid_i | input | 32 | Stream identifier of the current transaction |
| evtype_i | input | NUM_CTR*32 | Event-type words, counter c at bits c*32 +: 32 |
| smatch_i | input | NUM_CTR*32 | Stream-match words, counter c at bits c*32 +: 32 |
| inc_o | output | NUM_CTR | Registered increment strobe per counter |

## Verification
The assertions check on every cycle that no strobe appears without its selected pulse, and that out-of-range and unsupported events stay silent. They also check that a failed exact compare blocks the strobe, that the cycle event always passes, and that counters with equal event numbers agree in global mode. Only the bench scenarios can show the positive side of pattern matching, because that depends on where the lowest zero falls in chosen match values such as 0x42 and 0x47. The same holds for the all-ones accept-all case, for the irrelevance of the unused event-word bits, and for a counter following counter 0's filter against its own conflicting one.

// File: rtl/sef_pkg.sv
package sef_pkg;
  localparam int unsigned CFG_W        = 32;
  localparam int unsigned EVT_FIELD_W  = 16;
  localparam int unsigned SPAN_POS     = 29;
  localparam int unsigned ARCH_EVT_LIM = 128;

  typedef logic [CFG_W-1:0]       cfg_word_t;
  typedef logic [EVT_FIELD_W-1:0] evt_num_t;

  // Bits covered by the trailing-ones run plus its terminating zero.
  function automatic cfg_word_t pattern_ignore(input cfg_word_t m);
    cfg_word_t nxt;
    nxt = m + cfg_word_t'(1);
    return m ^ nxt;
  endfunction
endpackage

// File: rtl/sef_sid_match.sv
module sef_sid_match
  import sef_pkg::*;
(
  input  logic      span_i,
  input  cfg_word_t match_i,
  input  cfg_word_t sid_i,
  output logic      hit_o
);
  cfg_word_t ign;
  always_comb begin
    ign   = span_i ? pattern_ignore(match_i) : '0;
    hit_o = ((sid_i ^ match_i) & ~ign) == '0;
  end
endmodule

// File: rtl/sef_evt_pick.sv
module sef_evt_pick
  import sef_pkg::*;
#(
  parameter int unsigned         NUM_EVT = 8,
  parameter logic [NUM_EVT-1:0]  EVT_SUP = '1
) (
  input  evt_num_t           evt_num_i,
  input  logic [NUM_EVT-1:0] pulse_i,
  output logic               sel_o,
  output logic               is_cyc_o
);
  localparam int unsigned LIM = (NUM_EVT < ARCH_EVT_LIM) ? NUM_EVT : ARCH_EVT_LIM;

  always_comb begin
    sel_o = 1'b0;
    for (int e = 0; e < LIM; e++) begin
      if (evt_num_i == evt_num_t'(e)) sel_o = pulse_i[e] & EVT_SUP[e];
    end
    is_cyc_o = (evt_num_i == '0);
  end
endmodule

// File: rtl/stream_event_filter.sv
module stream_event_filter
  import sef_pkg::*;
#(
  parameter int unsigned        NUM_CTR = 4,
  parameter int unsigned        NUM_EVT = 8,
  parameter logic [NUM_EVT-1:0] EVT_SUP = '1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     global_mode_i,
  input  logic [NUM_EVT-1:0]       evt_pulse_i,
  input  logic [CFG_W-1:0]         sid_i,
  input  logic [NUM_CTR*CFG_W-1:0] evtype_i,
  input  logic [NUM_CTR*CFG_W-1:0] smatch_i,
  output logic [NUM_CTR-1:0]       inc_o
);
  logic [NUM_CTR-1:0] inc_d;
  logic [NUM_CTR-1:0] unused_cfg;

  for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
    cfg_word_t ev_word, own_match, f_match;
    logic      f_span, hit, sel, is_cyc;

    assign ev_word   = evtype_i[c*CFG_W +: CFG_W];
    assign own_match = smatch_i[c*CFG_W +: CFG_W];
    assign unused_cfg[c] = ^{ev_word[CFG_W-1:SPAN_POS+1], ev_word[SPAN_POS-1:EVT_FIELD_W]};

    // Global mode borrows the filter of counter 0.
    assign f_span  = global_mode_i ? evtype_i[SPAN_POS] : ev_word[SPAN_POS];
    assign f_match = global_mode_i ? smatch_i[CFG_W-1:0] : own_match;

    sef_sid_match i_match (
      .span_i  (f_span),
      .match_i (f_match),
      .sid_i   (sid_i),
      .hit_o   (hit)
    );

    sef_evt_pick #(.NUM_EVT(NUM_EVT), .EVT_SUP(EVT_SUP)) i_pick (
      .evt_num_i (ev_word[EVT_FIELD_W-1:0]),
      .pulse_i   (evt_pulse_i),
      .sel_o     (sel),
      .is_cyc_o  (is_cyc)
    );

    assign inc_d[c] = sel & (is_cyc | hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inc_o <= '0;
    else         inc_o <= inc_d;
  end
endmodule

// File: rtl/stream_event_filter_chk.sv
module stream_event_filter_chk
  import sef_pkg::*;
#(
  parameter int unsigned        NUM_CTR = 4,
  parameter int unsigned        NUM_EVT = 8,
  parameter logic [NUM_EVT-1:0] EVT_SUP = '1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     global_mode_i,
  input logic [NUM_EVT-1:0]       evt_pulse_i,
  input logic [CFG_W-1:0]         sid_i,
  input logic [NUM_CTR*CFG_W-1:0] evtype_i,
  input logic [NUM_CTR*CFG_W-1:0] smatch_i,
  input logic [NUM_CTR-1:0]       inc_o
);
  AST_NO_PULSE_NO_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_pulse_i == '0) |=> (inc_o == '0)); // R11

  for (genvar c = 0; c < NUM_CTR; c++) begin : g_c
    AST_RANGE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((evtype_i[c*CFG_W +: EVT_FIELD_W] >= EVT_FIELD_W'(NUM_EVT)) ||
       (evtype_i[c*CFG_W +: EVT_FIELD_W] >= EVT_FIELD_W'(ARCH_EVT_LIM))) |=> !inc_o[c]); // R6

    AST_EXACT_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!global_mode_i && !evtype_i[c*CFG_W + SPAN_POS] &&
       (evtype_i[c*CFG_W +: EVT_FIELD_W] != '0) &&
       (sid_i != smatch_i[c*CFG_W +: CFG_W])) |=> !inc_o[c]); // R2

    AST_GLOBAL_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (global_mode_i && (evtype_i[c*CFG_W +: EVT_FIELD_W] == evtype_i[EVT_FIELD_W-1:0]))
      |=> (inc_o[c] == inc_o[0])); // R8

    if (EVT_SUP[0]) begin : g_cyc
      AST_CYCLES_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((evtype_i[c*CFG_W +: EVT_FIELD_W] == '0) && evt_pulse_i[0]) |=> inc_o[c]); // R5
    end

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_e
      if (!EVT_SUP[e]) begin : g_uns
        AST_UNSUP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (evtype_i[c*CFG_W +: EVT_FIELD_W] == EVT_FIELD_W'(e)) |=> !inc_o[c]); // R7
      end
    end
  end
endmodule

bind stream_event_filter stream_event_filter_chk #(
  .NUM_CTR(NUM_CTR), .NUM_EVT(NUM_EVT), .EVT_SUP(EVT_SUP)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .global_mode_i(global_mode_i),
  .evt_pulse_i(evt_pulse_i), .sid_i(sid_i), .evtype_i(evtype_i),
  .smatch_i(smatch_i), .inc_o(inc_o)
);

// File: tb/test_stream_event_filter.sv
module test_stream_event_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NE = 8;
  localparam logic [NE-1:0] SUP = 8'hBF; // event 6 unsupported

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glob;
  logic [NE-1:0] pulse;
  logic [31:0] sid;
  logic [31:0] ev [NC];
  logic [31:0] mt [NC];
  logic [NC*32-1:0] ev_flat, mt_flat;
  logic [NC-1:0] inc;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      ev_flat[c*32 +: 32] = ev[c];
      mt_flat[c*32 +: 32] = mt[c];
    end
  end

  stream_event_filter #(.NUM_CTR(NC), .NUM_EVT(NE), .EVT_SUP(SUP)) i_stream_event_filter (
    .clk_i(clk), .rst_ni(rst_n), .global_mode_i(glob), .evt_pulse_i(pulse),
    .sid_i(sid), .evtype_i(ev_flat), .smatch_i(mt_flat), .inc_o(inc)
  );

  function automatic bit model(int c);
    logic [31:0] e, f, m;
    int n, z;
    e = ev[c];
    f = glob ? ev[0] : ev[c];
    m = glob ? mt[0] : mt[c];
    n = int'(e[15:0]);
    if (n >= NE) return 1'b0;
    if (!SUP[n]) return 1'b0;
    if (!pulse[n]) return 1'b0;
    if (n == 0) return 1'b1;
    if (!f[29]) return sid == m;
    z = 32;
    for (int i = 31; i >= 0; i--) if (!m[i]) z = i;
    for (int i = z + 1; i < 32; i++) if (sid[i] != m[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string tag, int c, bit exp);
    checks++;
    if (inc[c] !== exp) begin
      fails++;
      $display("FAIL %s ctr=%0d actual=%b expected=%b", tag, c, inc[c], exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_cfg();
    glob = 0; pulse = '0; sid = '0;
    for (int c = 0; c < NC; c++) begin ev[c] = 32'h0000_0001; mt[c] = '0; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    clear_cfg();
    pulse = '1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++) chk("R10 reset", c, 0);
    rst_n = 1;
    clear_cfg();
    step();
    for (int c = 0; c < NC; c++) chk("R10 idle", c, 0);

    // R3: 0x42 pattern accepts 0x42/0x43 only
    pulse = 8'h02; ev[0] = 32'h2000_0001; mt[0] = 32'h42;
    sid = 32'h42; step(); chk("R3 0x42", 0, 1);
    sid = 32'h43; step(); chk("R3 0x43", 0, 1);
    sid = 32'h40; step(); chk("R3 0x40", 0, 0);
    sid = 32'h44; step(); chk("R3 0x44", 0, 0);
    // R3: 0x47 ignores bits 3:0
    mt[0] = 32'h47;
    sid = 32'h40; step(); chk("R3 0x47/0x40", 0, 1);
    sid = 32'h4F; step(); chk("R3 0x47/0x4F", 0, 1);
    sid = 32'h50; step(); chk("R3 0x47/0x50", 0, 0);
    // R2 exact
    ev[0] = 32'h0000_0001; mt[0] = 32'h42;
    sid = 32'h43; step(); chk("R2 miss", 0, 0);
    sid = 32'h42; step(); chk("R2 hit", 0, 1);
    // R1 unused event-word bits
    ev[0] = 32'hC0AB_0001;
    sid = 32'h43; step(); chk("R1 junk exact miss", 0, 0);
    sid = 32'h42; step(); chk("R1 junk exact hit", 0, 1);
    // R4 accept all
    ev[0] = 32'h2000_0001; mt[0] = 32'hFFFF_FFFF;
    sid = 32'hDEAD_BEEF; step(); chk("R4 any", 0, 1);
    sid = 32'h0; step(); chk("R4 zero", 0, 1);
    // R5 cycles ignore filter
    ev[1] = 32'h0000_0000; mt[1] = 32'h1234; pulse = 8'h01; sid = 32'h99;
    step(); chk("R5 cycles", 1, 1);
    // R11 no pulse
    pulse = '0; step(); chk("R11 no pulse", 1, 0); chk("R11 no pulse", 0, 0);
    // R10 latency: one-cycle pulse shows one cycle later, then drops
    pulse = 8'h01; @(posedge clk); #1 pulse = '0; @(negedge clk);
    chk("R10 latency", 1, 1);
    step(); chk("R10 drop", 1, 0);
    // R6 out of range
    pulse = '1; mt[2] = '1; ev[2] = 32'h2000_0008; step(); chk("R6 evt8", 2, 0);
    ev[2] = 32'h2000_00C8; step(); chk("R6 evt200", 2, 0);
    // R7 unsupported
    ev[2] = 32'h2000_0006; step(); chk("R7 evt6", 2, 0);
    ev[2] = 32'h2000_0007; step(); chk("R7 evt7 ok", 2, 1);
    // R8 global vs R9 per-counter
    ev[0] = 32'h0000_0002; mt[0] = 32'h77; sid = 32'h77;
    ev[3] = 32'h0000_0003; mt[3] = 32'h10;
    glob = 1; step(); chk("R8 global follows ctr0", 3, 1);
    glob = 0; step(); chk("R9 own filter", 3, 0);
    mt[3] = 32'h77; pulse = 8'h04; glob = 1; step();
    chk("R8 own event", 3, 0); chk("R8 ctr0 event", 0, 1);

    // random
    for (int it = 0; it < 500; it++) begin
      int k;
      glob  = ($urandom % 3) == 0;
      pulse = NE'($urandom);
      sid   = $urandom & 32'hFF;
      for (int c = 0; c < NC; c++) begin
        ev[c] = ($urandom & 32'hDFFF_0000) | (32'($urandom % 2) << 29) | 32'($urandom % 10);
        k = int'($urandom % 6);
        case ($urandom % 4)
          0: mt[c] = sid;
          1: mt[c] = (sid & ~((32'd1 << (k + 1)) - 1)) | ((32'd1 << k) - 1);
          2: mt[c] = 32'hFFFF_FFFF;
          default: mt[c] = $urandom & 32'hFF;
        endcase
      end
      @(posedge clk);
      @(negedge clk);
      for (int c = 0; c < NC; c++) chk(glob ? "R8 random" : "R9 random", c, model(c));
    end
    finish_run();
  end
endmodule